// File: doc/BRIEF.md
# Two-Channel Hardware Breakpoint Unit

This block sits beside a processor core and watches every bus access the core makes, both instruction fetches and operand loads and stores. Software programs up to two watch conditions through a small word-addressed register window. When an access meets an enabled condition, the unit records a sticky match flag for that channel. If breaking is enabled for the channel, it also raises a one-cycle break request towards the core's exception logic.

A break can be taken before the matched instruction executes, or deferred until that instruction has retired. In the deferred case the saved program counter already points past it. The second channel can also qualify operand accesses on a masked data value. It can also count matches and fire only on the Nth one. A global control bit tells the core whether to enter the break through a dedicated debug vector or through the default one.

Top module: `brk_unit`

## Requirements
- R1: After reset every register reads 0, `brk_req`, `brk_after` and `brk_vec_sel` are 0, and no channel is enabled.
- R2: Register byte offsets (word aligned, `reg_addr[1:0]` ignored):
  - Channel 0: condition 0x00, operation 0x04, address 0x08, address mask 0x0C.
  - Channel 1: condition 0x10, operation 0x14, address 0x18, address mask 0x1C, data 0x20, data mask 0x24, count 0x28.
  - Shared: flags 0x30, control 0x34.
  - Reserved bits and unmapped offsets read 0.
  - Condition fields: bit0 enable, bits[2:1] access kind, bits[4:3] direction, bits[6:5] operand bus, bits[9:7] size, bit10 data-compare enable, bit11 count enable. Bits 10 and 11 exist in channel 1 only.
  - Operation fields: bit0 break enable, bit1 after-execution select.
  - Count is 12 bits. Control bit0 is the debug-vector select.
  - Reads are combinational in the same cycle.
- R3: A channel whose enable bit is 0 never matches and never sets its flag.
- R4: The access address is compared with the channel address on every bit whose address-mask bit is 0. Bits whose mask bit is 1 are ignored.
- R5: Kind bit0 admits instruction fetches and kind bit1 admits operand accesses. Direction bit0 admits reads and direction bit1 admits writes. A fetch always counts as a read.
- R6: Size and bus qualifiers apply to operand accesses only.
  - Size 0 matches any size; sizes 1, 2 and 3 match `bus_size` 0 (byte), 1 (word) and 2 (long) respectively; sizes 4 to 7 never match.
  - Bus field 0 or 3 matches either operand bus; 1 matches `bus_sel`=0; 2 matches `bus_sel`=1.
- R7: A match sets its channel's flag, which is readable in the cycle after the access. A write to the flag register clears each flag whose written bit is 0 and keeps those written 1. A match in the same cycle as a clearing write wins.
- R8: A match on a channel with break enable set and after-select 0 drives `brk_req` high with `brk_after` low for exactly the one cycle after the access.
- R9: With after-select 1, the request is held pending until `insn_retire` is seen in a later cycle. `brk_req` and `brk_after` are then both high for the one cycle that follows.
- R10: With break enable 0, a match sets the flag but raises no request.
- R11: When channel 1's data-compare enable is set, an operand access matches only if its data equals the data register on every bit whose data-mask bit is 0. When the enable is clear, the data is ignored.
- R12: With channel 1's count enable set, each otherwise-qualified match above 1 decrements the count and does not match. A qualified match at count 1 decrements it to 0 and matches. At count 0 every qualified match matches and the count stays at 0.
- R13: Simultaneous matches on both channels set both flags and raise one request. An immediate break outranks, and discards, a deferred one pending from the same or an earlier access.
- R14: `brk_vec_sel` follows control bit0 from the cycle after it is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_en | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 6 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational |
| bus_valid | input | 1 | A core access is presented this cycle |
| bus_fetch | input | 1 | 1 = instruction fetch, 0 = operand access |
| bus_write | input | 1 | Operand write when 1 |
| bus_sel | input | 1 | Which operand bus carries the access |
| bus_size | input | 2 | 0 byte, 1 word, 2 long |
| bus_addr | input | 32 | Access address |
| bus_data | input | 32 | Operand data |
| insn_retire | input | 1 | The instruction of a pending deferred break has retired |
| brk_req | output | 1 | One-cycle break request |
| brk_after | output | 1 | Qualifies `brk_req`: deferred (after-execution) break |
| brk_vec_sel | output | 1 | Use the debug vector for break entry |

## Verification
On every cycle the assertions check several behaviours:
- an immediate request always follows a bus access, and a deferred one always follows a retire pulse;
- a cycle with both channels disabled raises no flag;
- every comparator hit lands in its flag;
- the execution count never wraps below zero.

Only the bench scenarios can show the qualifiers actually working. The bench sweeps kind against direction, size against bus size, bus select, and every address and data mask bit. The cycle exactly one after a deferred break's retire, the count sequence, and the priority between the two channels are also seen only in directed scenarios.

// File: rtl/brk_pkg.sv
package brk_pkg;

    localparam int NCH   = 2;
    localparam int CH_W  = $clog2(NCH);
    localparam int REG_W = 32;
    localparam int RA_W  = 6;
    localparam int IDX_W = RA_W - 2;
    localparam int CNT_W = 12;

    // word indices of the shared registers (byte offset >> 2)
    localparam logic [IDX_W-1:0] IDX_DATA1  = 4'h8;
    localparam logic [IDX_W-1:0] IDX_DMASK1 = 4'h9;
    localparam logic [IDX_W-1:0] IDX_CNT1   = 4'hA;
    localparam logic [IDX_W-1:0] IDX_FLAG   = 4'hC;
    localparam logic [IDX_W-1:0] IDX_CTRL   = 4'hD;

    typedef enum logic [1:0] {
        CR_COND = 2'd0,
        CR_OP   = 2'd1,
        CR_ADDR = 2'd2,
        CR_MASK = 2'd3
    } chreg_e;

    typedef struct packed {
        logic [19:0] rsv;
        logic        cnt_en;
        logic        data_en;
        logic [2:0]  size;
        logic [1:0]  bsel;
        logic [1:0]  dir;
        logic [1:0]  kind;
        logic        en;
    } cond_t;

    typedef struct packed {
        logic [29:0] rsv;
        logic        after;
        logic        brk_en;
    } op_t;

    typedef struct packed {
        logic             valid;
        logic             fetch;
        logic             write;
        logic             sel;
        logic [1:0]       size;
        logic [REG_W-1:0] addr;
        logic [REG_W-1:0] data;
    } bus_t;

    function automatic cond_t cond_clean(input logic [REG_W-1:0] w, input logic ext);
        cond_t c;
        c     = cond_t'(w);
        c.rsv = '0;
        if (!ext) begin
            c.cnt_en  = 1'b0;
            c.data_en = 1'b0;
        end
        return c;
    endfunction

    function automatic op_t op_clean(input logic [REG_W-1:0] w);
        op_t o;
        o     = op_t'(w);
        o.rsv = '0;
        return o;
    endfunction

    function automatic logic masked_eq(input logic [REG_W-1:0] a, input logic [REG_W-1:0] b,
                                       input logic [REG_W-1:0] m);
        return ((a ^ b) & ~m) == '0;
    endfunction

    function automatic logic kind_ok(input logic [1:0] kind, input logic fetch);
        return fetch ? kind[0] : kind[1];
    endfunction

    function automatic logic dir_ok(input logic [1:0] dir, input logic fetch, input logic write);
        return (fetch || !write) ? dir[0] : dir[1];
    endfunction

    function automatic logic size_ok(input logic [2:0] sz, input logic [1:0] bsz);
        return (sz == 3'd0) || (sz == ({1'b0, bsz} + 3'd1));
    endfunction

    function automatic logic bus_ok(input logic [1:0] bsel, input logic sel);
        return (bsel == 2'd0) || (bsel == 2'd3) || (bsel == ({1'b0, sel} + 2'd1));
    endfunction

endpackage

// File: rtl/brk_regs.sv
module brk_regs
    import brk_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        reg_en,
    input  logic                        reg_wr,
    input  logic [RA_W-1:0]             reg_addr,
    input  logic [REG_W-1:0]            reg_wdata,
    output logic [REG_W-1:0]            reg_rdata,
    input  logic [NCH-1:0]              hit,
    input  logic                        cnt_dec,
    output cond_t [NCH-1:0]             cond_o,
    output op_t   [NCH-1:0]             op_o,
    output logic  [NCH-1:0][REG_W-1:0]  addr_o,
    output logic  [NCH-1:0][REG_W-1:0]  amask_o,
    output logic [REG_W-1:0]            data_o,
    output logic [REG_W-1:0]            dmask_o,
    output logic [CNT_W-1:0]            cnt_o,
    output logic [NCH-1:0]              flag_o,
    output logic                        vec_sel_o
);

    logic [IDX_W-1:0] idx;
    logic             wr_en;
    logic             chan_area;
    logic [1:0]       unused_lo;

    assign idx       = reg_addr[RA_W-1:2];
    assign wr_en     = reg_en && reg_wr;
    assign chan_area = !idx[IDX_W-1];
    assign unused_lo = reg_addr[1:0];

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        localparam logic EXT = (c == NCH - 1);
        cond_t            cond_r;
        op_t              op_r;
        logic [REG_W-1:0] addr_r;
        logic [REG_W-1:0] amsk_r;
        logic             sel_w;

        assign sel_w = wr_en && chan_area && (idx[2 +: CH_W] == CH_W'(c));

        always_ff @(posedge clk) begin
            if (rst) begin
                cond_r <= '0;
                op_r   <= '0;
                addr_r <= '0;
                amsk_r <= '0;
            end else if (sel_w) begin
                unique case (chreg_e'(idx[1:0]))
                    CR_COND: cond_r <= cond_clean(reg_wdata, EXT);
                    CR_OP:   op_r   <= op_clean(reg_wdata);
                    CR_ADDR: addr_r <= reg_wdata;
                    CR_MASK: amsk_r <= reg_wdata;
                endcase
            end
        end

        assign cond_o[c]  = cond_r;
        assign op_o[c]    = op_r;
        assign addr_o[c]  = addr_r;
        assign amask_o[c] = amsk_r;
    end

    logic [REG_W-1:0] data_q, dmask_q;
    logic [CNT_W-1:0] cnt_q;
    logic [NCH-1:0]   flag_q;
    logic             vec_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q  <= '0;
            dmask_q <= '0;
            cnt_q   <= '0;
            flag_q  <= '0;
            vec_q   <= 1'b0;
        end else begin
            if (wr_en && idx == IDX_DATA1)  data_q  <= reg_wdata;
            if (wr_en && idx == IDX_DMASK1) dmask_q <= reg_wdata;
            if (wr_en && idx == IDX_CTRL)   vec_q   <= reg_wdata[0];
            if (wr_en && idx == IDX_CNT1)
                cnt_q <= reg_wdata[CNT_W-1:0];
            else if (cnt_dec)
                cnt_q <= cnt_q - CNT_W'(1);
            if (wr_en && idx == IDX_FLAG)
                flag_q <= (flag_q & reg_wdata[NCH-1:0]) | hit;
            else
                flag_q <= flag_q | hit;
        end
    end

    assign data_o    = data_q;
    assign dmask_o   = dmask_q;
    assign cnt_o     = cnt_q;
    assign flag_o    = flag_q;
    assign vec_sel_o = vec_q;

    always_comb begin
        reg_rdata = '0;
        if (reg_en && !reg_wr) begin
            if (chan_area) begin
                unique case (chreg_e'(idx[1:0]))
                    CR_COND: reg_rdata = cond_o[idx[2 +: CH_W]];
                    CR_OP:   reg_rdata = op_o[idx[2 +: CH_W]];
                    CR_ADDR: reg_rdata = addr_o[idx[2 +: CH_W]];
                    CR_MASK: reg_rdata = amask_o[idx[2 +: CH_W]];
                endcase
            end else begin
                case (idx)
                    IDX_DATA1:  reg_rdata = data_q;
                    IDX_DMASK1: reg_rdata = dmask_q;
                    IDX_CNT1:   reg_rdata = REG_W'(cnt_q);
                    IDX_FLAG:   reg_rdata = REG_W'(flag_q);
                    IDX_CTRL:   reg_rdata = REG_W'(vec_q);
                    default:    reg_rdata = '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/brk_chan.sv
module brk_chan
    import brk_pkg::*;
#(
    parameter bit HAS_EXT = 1'b0,
    parameter int CW      = CNT_W
) (
    input  cond_t            cond,
    input  logic [REG_W-1:0] addr_cmp,
    input  logic [REG_W-1:0] addr_msk,
    input  logic [REG_W-1:0] data_cmp,
    input  logic [REG_W-1:0] data_msk,
    input  logic [CW-1:0]    cnt,
    input  bus_t             bus,
    output logic             hit,
    output logic             cnt_dec
);

    logic addr_ok, qual_ok, oper_ok, raw;
    logic [19:0] unused_rsv;

    assign unused_rsv = cond.rsv;
    assign addr_ok    = masked_eq(bus.addr, addr_cmp, addr_msk);
    assign qual_ok    = kind_ok(cond.kind, bus.fetch) && dir_ok(cond.dir, bus.fetch, bus.write);

    if (HAS_EXT) begin : g_ext
        logic data_ok;
        logic at_last, at_zero;

        assign data_ok = !cond.data_en || masked_eq(bus.data, data_cmp, data_msk);
        assign oper_ok = size_ok(cond.size, bus.size) && bus_ok(cond.bsel, bus.sel) && data_ok;
        assign at_zero = (cnt == '0);
        assign at_last = (cnt == CW'(1));

        always_comb begin
            if (cond.cnt_en) begin
                hit     = raw && (at_zero || at_last);
                cnt_dec = raw && !at_zero;
            end else begin
                hit     = raw;
                cnt_dec = 1'b0;
            end
        end
    end else begin : g_base
        logic unused_ext;
        assign unused_ext = ^{data_cmp, data_msk, cnt, bus.data, cond.data_en, cond.cnt_en};
        assign oper_ok    = size_ok(cond.size, bus.size) && bus_ok(cond.bsel, bus.sel);
        assign hit        = raw;
        assign cnt_dec    = 1'b0;
    end

    assign raw = bus.valid && cond.en && addr_ok && qual_ok && (bus.fetch || oper_ok);

endmodule

// File: rtl/brk_req.sv
module brk_req
    import brk_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] hit,
    input  logic [NCH-1:0] brk_en,
    input  logic [NCH-1:0] after,
    input  logic           retire,
    output logic           req_o,
    output logic           after_o
);

    logic req_q, after_q, pend_q;
    logic want_now, want_late, fire_late;

    assign want_now  = |(hit & brk_en & ~after);
    assign want_late = |(hit & brk_en & after);
    assign fire_late = pend_q && retire;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q   <= 1'b0;
            after_q <= 1'b0;
            pend_q  <= 1'b0;
        end else if (want_now) begin
            req_q   <= 1'b1;
            after_q <= 1'b0;
            pend_q  <= 1'b0;
        end else begin
            req_q   <= fire_late;
            after_q <= fire_late;
            pend_q  <= (pend_q && !retire) || want_late;
        end
    end

    assign req_o   = req_q;
    assign after_o = after_q;

endmodule

// File: rtl/brk_unit.sv
module brk_unit
    import brk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_en,
    input  logic             reg_wr,
    input  logic [RA_W-1:0]  reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             bus_valid,
    input  logic             bus_fetch,
    input  logic             bus_write,
    input  logic             bus_sel,
    input  logic [1:0]       bus_size,
    input  logic [REG_W-1:0] bus_addr,
    input  logic [REG_W-1:0] bus_data,
    input  logic             insn_retire,
    output logic             brk_req,
    output logic             brk_after,
    output logic             brk_vec_sel
);

    bus_t                       bus;
    cond_t [NCH-1:0]            cond_v;
    op_t   [NCH-1:0]            op_v;
    logic  [NCH-1:0][REG_W-1:0] addr_v, amask_v, dcmp_v, dmsk_v;
    logic  [REG_W-1:0]          data1, dmask1;
    logic  [CNT_W-1:0]          cnt_v;
    logic  [NCH-1:0]            chan_hit, dec_v, flag_v, chan_en, brk_en_v, after_v;
    logic                       unused_dec;

    always_comb begin
        bus.valid = bus_valid;
        bus.fetch = bus_fetch;
        bus.write = bus_write;
        bus.sel   = bus_sel;
        bus.size  = bus_size;
        bus.addr  = bus_addr;
        bus.data  = bus_data;
    end

    brk_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_en    (reg_en),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .hit       (chan_hit),
        .cnt_dec   (dec_v[NCH-1]),
        .cond_o    (cond_v),
        .op_o      (op_v),
        .addr_o    (addr_v),
        .amask_o   (amask_v),
        .data_o    (data1),
        .dmask_o   (dmask1),
        .cnt_o     (cnt_v),
        .flag_o    (flag_v),
        .vec_sel_o (brk_vec_sel)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        localparam bit EXT = (i == NCH - 1);

        assign dcmp_v[i]   = EXT ? data1 : '0;
        assign dmsk_v[i]   = EXT ? dmask1 : '0;
        assign chan_en[i]  = cond_v[i].en;
        assign brk_en_v[i] = op_v[i].brk_en;
        assign after_v[i]  = op_v[i].after;

        brk_chan #(.HAS_EXT(EXT), .CW(CNT_W)) u_chan (
            .cond     (cond_v[i]),
            .addr_cmp (addr_v[i]),
            .addr_msk (amask_v[i]),
            .data_cmp (dcmp_v[i]),
            .data_msk (dmsk_v[i]),
            .cnt      (cnt_v),
            .bus      (bus),
            .hit      (chan_hit[i]),
            .cnt_dec  (dec_v[i])
        );
    end

    assign unused_dec = ^{dec_v[NCH-2:0], op_v[0].rsv, op_v[NCH-1].rsv};

    brk_req u_req (
        .clk     (clk),
        .rst     (rst),
        .hit     (chan_hit),
        .brk_en  (brk_en_v),
        .after   (after_v),
        .retire  (insn_retire),
        .req_o   (brk_req),
        .after_o (brk_after)
    );

endmodule

// File: rtl/brk_unit_chk.sv
module brk_unit_chk
    import brk_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             reg_en,
    input logic             reg_wr,
    input logic [RA_W-1:0]  reg_addr,
    input logic             bus_valid,
    input logic             insn_retire,
    input logic             brk_req,
    input logic             brk_after,
    input logic [NCH-1:0]   en_v,
    input logic [NCH-1:0]   hit_v,
    input logic [NCH-1:0]   flags,
    input logic [CNT_W-1:0] cnt1
);

    logic cnt_wr;
    logic [1:0] unused_lo;

    assign cnt_wr    = reg_en && reg_wr && (reg_addr[RA_W-1:2] == IDX_CNT1);
    assign unused_lo = reg_addr[1:0];

    // R3
    no_flag_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        (en_v == '0) |=> ((flags & ~$past(flags)) == '0));

    // R7
    hit_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (hit_v != '0) |=> ((flags & $past(hit_v)) == $past(hit_v)));

    // R8
    before_follows_access_chk: assert property (@(posedge clk) disable iff (rst)
        (brk_req && !brk_after) |-> $past(bus_valid));

    // R9
    after_follows_retire_chk: assert property (@(posedge clk) disable iff (rst)
        (brk_req && brk_after) |-> $past(insn_retire));

    // R12
    count_floor_chk: assert property (@(posedge clk) disable iff (rst)
        ((cnt1 == '0) && !cnt_wr) |=> (cnt1 == '0));

    // R9
    after_qualifies_req_chk: assert property (@(posedge clk) disable iff (rst)
        brk_after |-> brk_req);

endmodule

bind brk_unit brk_unit_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .reg_en      (reg_en),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .bus_valid   (bus_valid),
    .insn_retire (insn_retire),
    .brk_req     (brk_req),
    .brk_after   (brk_after),
    .en_v        (chan_en),
    .hit_v       (chan_hit),
    .flags       (flag_v),
    .cnt1        (cnt_v)
);

// File: tb/tb_brk_unit.sv
module tb_brk_unit;

    localparam logic [5:0] A_COND0 = 6'h00, A_OP0 = 6'h04, A_ADDR0 = 6'h08, A_MASK0 = 6'h0C;
    localparam logic [5:0] A_COND1 = 6'h10, A_OP1 = 6'h14, A_ADDR1 = 6'h18, A_MASK1 = 6'h1C;
    localparam logic [5:0] A_DATA1 = 6'h20, A_DMASK1 = 6'h24, A_CNT1 = 6'h28;
    localparam logic [5:0] A_FLAG = 6'h30, A_CTRL = 6'h34;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_en, reg_wr;
    logic [5:0]  reg_addr;
    logic [31:0] reg_wdata, reg_rdata;
    logic        bus_valid, bus_fetch, bus_write, bus_sel;
    logic [1:0]  bus_size;
    logic [31:0] bus_addr, bus_data;
    logic        insn_retire;
    logic        brk_req, brk_after, brk_vec_sel;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    brk_unit dut (
        .clk(clk), .rst(rst), .reg_en(reg_en), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_valid(bus_valid),
        .bus_fetch(bus_fetch), .bus_write(bus_write), .bus_sel(bus_sel),
        .bus_size(bus_size), .bus_addr(bus_addr), .bus_data(bus_data),
        .insn_retire(insn_retire), .brk_req(brk_req), .brk_after(brk_after),
        .brk_vec_sel(brk_vec_sel)
    );

    function automatic logic [31:0] mkc(input logic en, input logic [1:0] kind, input logic [1:0] dir,
                                        input logic [1:0] bsel, input logic [2:0] size,
                                        input logic den, input logic cen);
        return {20'd0, cen, den, size, bsel, dir, kind, en};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_en = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_en = 1'b0; reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        reg_en = 1'b1; reg_wr = 1'b0; reg_addr = a;
        #1;
        d = reg_rdata;
        reg_en = 1'b0;
    endtask

    task automatic acc(input logic f, input logic w, input logic s, input logic [1:0] sz,
                       input logic [31:0] a, input logic [31:0] d,
                       output logic rq, output logic af);
        @(negedge clk);
        bus_valid = 1'b1; bus_fetch = f; bus_write = w; bus_sel = s;
        bus_size = sz; bus_addr = a; bus_data = d;
        @(negedge clk);
        bus_valid = 1'b0;
        #1;
        rq = brk_req; af = brk_after;
    endtask

    task automatic idle(output logic rq, output logic af);
        @(negedge clk);
        #1;
        rq = brk_req; af = brk_after;
    endtask

    task automatic retire(output logic rq, output logic af);
        @(negedge clk);
        insn_retire = 1'b1;
        @(negedge clk);
        insn_retire = 1'b0;
        #1;
        rq = brk_req; af = brk_after;
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: actual running expected finished");
            report();
            $finish;
        end
    end

    initial begin
        logic [31:0] rv;
        logic        rq, af, e;
        rst = 1'b1; reg_en = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
        bus_valid = 1'b0; bus_fetch = 1'b0; bus_write = 1'b0; bus_sel = 1'b0;
        bus_size = '0; bus_addr = '0; bus_data = '0; insn_retire = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        for (int a = 0; a < 16; a++) begin
            rd(6'(a * 4), rv);
            chk("R1 reset reg", rv, 32'd0);
        end
        chk("R1 brk_req", {31'd0, brk_req}, 32'd0);
        chk("R1 brk_after", {31'd0, brk_after}, 32'd0);
        chk("R1 vec_sel", {31'd0, brk_vec_sel}, 32'd0);

        // R2: readback and reserved bits
        wr(A_COND0, 32'hFFFF_FFFF); rd(A_COND0, rv); chk("R2 cond0", rv, 32'h0000_03FF);
        wr(A_COND1, 32'hFFFF_FFFF); rd(A_COND1, rv); chk("R2 cond1", rv, 32'h0000_0FFF);
        wr(A_OP0, 32'hFFFF_FFFF);   rd(A_OP0, rv);   chk("R2 op0", rv, 32'h3);
        wr(A_ADDR1, 32'h1234_5678); rd(A_ADDR1, rv); chk("R2 addr1", rv, 32'h1234_5678);
        wr(A_MASK0, 32'h8765_4321); rd(A_MASK0, rv); chk("R2 mask0", rv, 32'h8765_4321);
        wr(A_DMASK1, 32'hCAFE_F00D); rd(A_DMASK1, rv); chk("R2 dmask1", rv, 32'hCAFE_F00D);
        wr(A_CNT1, 32'hFFFF_FFFF);  rd(A_CNT1, rv);  chk("R2 cnt1", rv, 32'h0000_0FFF);
        rd(6'h2C, rv); chk("R2 unmapped 2C", rv, 32'd0);
        rd(6'h38, rv); chk("R2 unmapped 38", rv, 32'd0);
        wr(A_COND0, 0); wr(A_COND1, 0); wr(A_OP0, 0); wr(A_ADDR1, 0); wr(A_MASK0, 0);
        wr(A_DMASK1, 0); wr(A_CNT1, 0);

        // R14: vector select
        wr(A_CTRL, 32'hFFFF_FFFF); #1 chk("R14 vec_sel set", {31'd0, brk_vec_sel}, 32'd1);
        rd(A_CTRL, rv); chk("R14 ctrl read", rv, 32'd1);
        wr(A_CTRL, 0); #1 chk("R14 vec_sel clear", {31'd0, brk_vec_sel}, 32'd0);

        // R5: kind x direction x fetch x write sweep on channel 0
        wr(A_ADDR0, 32'h0000_4000); wr(A_OP0, 32'h1);
        for (int k = 0; k < 4; k++) begin
            for (int d = 0; d < 4; d++) begin
                for (int f = 0; f < 2; f++) begin
                    for (int w = 0; w < 2; w++) begin
                        logic [1:0] kk, dd;
                        kk = 2'(k); dd = 2'(d);
                        e = (f != 0) ? kk[0] : kk[1];
                        e = e && (((f != 0) || (w == 0)) ? dd[0] : dd[1]);
                        wr(A_COND0, mkc(1'b1, kk, dd, 2'd0, 3'd0, 1'b0, 1'b0));
                        acc(1'(f), 1'(w), 1'b0, 2'd2, 32'h0000_4000, 32'd0, rq, af);
                        chk("R5 req", {31'd0, rq}, {31'd0, e});
                        rd(A_FLAG, rv); chk("R5 flag", rv, {31'd0, e});
                        wr(A_FLAG, 0);
                    end
                end
            end
        end

        // R3: disabled channel
        wr(A_COND0, mkc(1'b0, 2'd3, 2'd3, 2'd0, 3'd0, 1'b0, 1'b0));
        acc(1'b1, 1'b0, 1'b0, 2'd0, 32'h0000_4000, 32'd0, rq, af);
        chk("R3 req off", {31'd0, rq}, 32'd0);
        rd(A_FLAG, rv); chk("R3 flag off", rv, 32'd0);

        // R4: address mask sweep
        wr(A_COND0, mkc(1'b1, 2'd3, 2'd3, 2'd0, 3'd0, 1'b0, 1'b0));
        wr(A_ADDR0, 32'h5A5A_C3C3);
        for (int b = 0; b < 32; b++) begin
            wr(A_MASK0, 32'd0);
            acc(1'b1, 1'b0, 1'b0, 2'd0, 32'h5A5A_C3C3 ^ (32'd1 << b), 32'd0, rq, af);
            chk("R4 bit compared", {31'd0, rq}, 32'd0);
            wr(A_MASK0, 32'd1 << b);
            acc(1'b1, 1'b0, 1'b0, 2'd0, 32'h5A5A_C3C3 ^ (32'd1 << b), 32'd0, rq, af);
            chk("R4 bit masked", {31'd0, rq}, 32'd1);
            wr(A_FLAG, 0);
        end
        wr(A_MASK0, 0);
        wr(A_ADDR0, 32'h0000_4000);

        // R6: size sweep and bus select sweep (operand reads)
        for (int s = 0; s < 8; s++) begin
            for (int z = 0; z < 3; z++) begin
                e = (s == 0) || (s == z + 1);
                wr(A_COND0, mkc(1'b1, 2'd2, 2'd1, 2'd0, 3'(s), 1'b0, 1'b0));
                acc(1'b0, 1'b0, 1'b0, 2'(z), 32'h0000_4000, 32'd0, rq, af);
                chk("R6 size", {31'd0, rq}, {31'd0, e});
            end
        end
        for (int b = 0; b < 4; b++) begin
            for (int s = 0; s < 2; s++) begin
                e = (b == 0) || (b == 3) || (b == s + 1);
                wr(A_COND0, mkc(1'b1, 2'd2, 2'd1, 2'(b), 3'd0, 1'b0, 1'b0));
                acc(1'b0, 1'b0, 1'(s), 2'd0, 32'h0000_4000, 32'd0, rq, af);
                chk("R6 bus sel", {31'd0, rq}, {31'd0, e});
            end
        end
        wr(A_COND0, mkc(1'b1, 2'd1, 2'd1, 2'd2, 3'd5, 1'b0, 1'b0));
        acc(1'b1, 1'b0, 1'b1, 2'd0, 32'h0000_4000, 32'd0, rq, af);
        chk("R6 fetch ignores size/bus", {31'd0, rq}, 32'd1);
        wr(A_FLAG, 0);

        // R10: break disabled but flag set
        wr(A_COND0, mkc(1'b1, 2'd3, 2'd3, 2'd0, 3'd0, 1'b0, 1'b0));
        wr(A_OP0, 32'h0);
        acc(1'b1, 1'b0, 1'b0, 2'd0, 32'h0000_4000, 32'd0, rq, af);
        chk("R10 no req", {31'd0, rq}, 32'd0);
        rd(A_FLAG, rv); chk("R10 flag", rv, 32'd1);
        wr(A_FLAG, 0);

        // R8: before-mode single pulse
        wr(A_OP0, 32'h1);
        acc(1'b1, 1'b0, 1'b0, 2'd0, 32'h0000_4000, 32'd0, rq, af);
        chk("R8 req", {30'd0, rq, af}, 32'h2);
        idle(rq, af);
        chk("R8 pulse ends", {31'd0, rq}, 32'd0);
        wr(A_FLAG, 0);

        // R9: after-mode waits for retire
        wr(A_OP0, 32'h3);
        acc(1'b1, 1'b0, 1'b0, 2'd0, 32'h0000_4000, 32'd0, rq, af);
        chk("R9 no req before retire", {31'd0, rq}, 32'd0);
        idle(rq, af);
        chk("R9 still pending", {31'd0, rq}, 32'd0);
        retire(rq, af);
        chk("R9 req after retire", {30'd0, rq, af}, 32'h3);
        idle(rq, af);
        chk("R9 pulse ends", {31'd0, rq}, 32'd0);
        rd(A_FLAG, rv); chk("R9 flag", rv, 32'd1);
        wr(A_FLAG, 0);

        // R7: set wins over clearing write; selective clear
        wr(A_OP0, 32'h1);
        @(negedge clk);
        bus_valid = 1'b1; bus_fetch = 1'b1; bus_write = 1'b0; bus_addr = 32'h0000_4000;
        reg_en = 1'b1; reg_wr = 1'b1; reg_addr = A_FLAG; reg_wdata = 32'd0;
        @(negedge clk);
        bus_valid = 1'b0; reg_en = 1'b0; reg_wr = 1'b0;
        rd(A_FLAG, rv); chk("R7 set beats clear", rv, 32'd1);
        wr(A_FLAG, 0);
        rd(A_FLAG, rv); chk("R7 cleared", rv, 32'd0);

        // R13: both channels at once
        wr(A_COND1, mkc(1'b1, 2'd3, 2'd3, 2'd0, 3'd0, 1'b0, 1'b0));
        wr(A_ADDR1, 32'h0000_4000); wr(A_OP1, 32'h1);
        acc(1'b1, 1'b0, 1'b0, 2'd0, 32'h0000_4000, 32'd0, rq, af);
        chk("R13 one req", {30'd0, rq, af}, 32'h2);
        rd(A_FLAG, rv); chk("R13 both flags", rv, 32'h3);
        idle(rq, af);
        chk("R13 single cycle", {31'd0, rq}, 32'd0);
        wr(A_FLAG, 32'h2);
        rd(A_FLAG, rv); chk("R7 keep bit1 clear bit0", rv, 32'h2);
        wr(A_FLAG, 0);
        wr(A_OP0, 32'h3);
        acc(1'b1, 1'b0, 1'b0, 2'd0, 32'h0000_4000, 32'd0, rq, af);
        chk("R13 before wins", {30'd0, rq, af}, 32'h2);
        retire(rq, af);
        chk("R13 after discarded", {31'd0, rq}, 32'd0);
        wr(A_FLAG, 0);

        // R11: channel 1 data compare
        wr(A_COND0, 0);
        wr(A_COND1, mkc(1'b1, 2'd2, 2'd3, 2'd0, 3'd0, 1'b1, 1'b0));
        wr(A_DATA1, 32'hA5A5_0000); wr(A_DMASK1, 32'h0000_FFFF);
        acc(1'b0, 1'b1, 1'b0, 2'd2, 32'h0000_4000, 32'hA5A5_1234, rq, af);
        chk("R11 masked low half", {31'd0, rq}, 32'd1);
        for (int b = 0; b < 32; b++) begin
            e = (b < 16);
            acc(1'b0, 1'b0, 1'b0, 2'd2, 32'h0000_4000, 32'hA5A5_0000 ^ (32'd1 << b), rq, af);
            chk("R11 data bit", {31'd0, rq}, {31'd0, e});
        end
        wr(A_COND1, mkc(1'b1, 2'd2, 2'd3, 2'd0, 3'd0, 1'b0, 1'b0));
        acc(1'b0, 1'b0, 1'b0, 2'd2, 32'h0000_4000, 32'h0000_0000, rq, af);
        chk("R11 data ignored", {31'd0, rq}, 32'd1);
        wr(A_FLAG, 0);

        // R12: execution count on channel 1
        wr(A_COND1, mkc(1'b1, 2'd3, 2'd3, 2'd0, 3'd0, 1'b0, 1'b1));
        wr(A_CNT1, 32'd3);
        acc(1'b1, 1'b0, 1'b0, 2'd0, 32'h0000_4000, 32'd0, rq, af);
        chk("R12 first no req", {31'd0, rq}, 32'd0);
        rd(A_FLAG, rv); chk("R12 first no flag", rv, 32'd0);
        rd(A_CNT1, rv); chk("R12 count 2", rv, 32'd2);
        acc(1'b1, 1'b0, 1'b0, 2'd0, 32'h0000_4000, 32'd0, rq, af);
        chk("R12 second no req", {31'd0, rq}, 32'd0);
        rd(A_CNT1, rv); chk("R12 count 1", rv, 32'd1);
        acc(1'b1, 1'b0, 1'b0, 2'd0, 32'h0000_4000, 32'd0, rq, af);
        chk("R12 third req", {31'd0, rq}, 32'd1);
        rd(A_FLAG, rv); chk("R12 third flag", rv, 32'h2);
        rd(A_CNT1, rv); chk("R12 count 0", rv, 32'd0);
        acc(1'b1, 1'b0, 1'b0, 2'd0, 32'h0000_4000, 32'd0, rq, af);
        chk("R12 fourth req", {31'd0, rq}, 32'd1);
        rd(A_CNT1, rv); chk("R12 count stays 0", rv, 32'd0);

        done = 1'b1;
        report();
        $finish;
    end

endmodule